// File: doc/BRIEF.md
# Multicycle 16-bit Teaching CPU Core

The block is a small processor core that runs a reduced 16-bit, word-addressed instruction set. It has eight general-purpose registers and a three-bit condition code with negative, zero and positive flags. A state machine fetches one instruction at a time from a single shared memory, decodes it and executes it. It supports register and immediate add, register and immediate AND, bitwise complement, a conditional PC-relative branch, PC-relative load and store, and a halting trap.

All memory traffic passes through an internal address register that drives the memory address. Read data is captured into an internal data register, which is loaded only by read accesses. The memory is single-ported and synchronous, and returns read data one cycle after the request. A debug port reads any register combinationally. Two outputs report that the core has stopped, either normally or on an instruction it does not support.

Top module: `tiny16_core`

## Requirements
- R1: After reset is released, the first memory read uses address x3000. During reset every register reads 0, `halted` and `illegal` are low and only the Z flag is set, so a branch-if-zero executed first is taken.
- R2: Opcode 0001 (add) writes DR[11:9] = SR1[8:6] + operand, wrapping modulo 2^16. The operand is the sign-extended imm5 in [4:0] when bit 5 is 1, and register [2:0] when bit 5 is 0.
- R3: Opcode 0101 (AND) writes DR = SR1 AND operand, choosing the operand by bit 5 as in R2.
- R4: Opcode 1001 with [5:0] = 111111 writes DR[11:9] = NOT SR[8:6]. Opcode 1001 with any other low bits is an unsupported instruction (R10).
- R5: Add, AND, NOT and load set exactly one flag from the value written. N means bit 15 is 1, Z means the value is zero and P means the value is positive. The flags are held until the next such instruction.
- R6: Opcode 0000 with mask n,z,p in [11:9] and signed offset [8:0] sets PC to (address of branch + 1) + offset when the mask ANDed with the flags is nonzero. Otherwise execution continues at the next word. Mask 000 never branches and mask 111 always branches.
- R7: Opcode 0010 loads DR[11:9] from memory at (address of load + 1) + sign-extended [8:0], and sets the flags from the loaded value.
- R8: Opcode 0011 writes register [11:9] to memory at (address of store + 1) + sign-extended [8:0], using one write cycle.
- R9: Opcode 1111 with [11:8] = 0000 and vector [7:0] = x25 raises `halted`. It stays high until reset, with no further memory reads or writes.
- R10: Opcodes 0100, 0110, 0111, 1000 and 1010 through 1110, a trap with any other vector or nonzero [11:8], and a NOT whose low bits are not 111111 all raise `illegal` and `halted` together, with no register change.
- R11: Each instruction takes 4 fetch cycles plus its execute cycles: 1 for add, AND, NOT, branch and trap, 4 for load and 2 for store. Each read request lasts one cycle and is never combined with a write.
- R12: `dbg_data` shows the current value of the register selected by `dbg_sel` in the same cycle, without clocking.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 16 | Memory address, driven from the address register |
| mem_re | output | 1 | Read request; data is returned on the next cycle |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Registered read data from memory |
| dbg_sel | input | 3 | Register index for the debug read |
| dbg_data | output | 16 | Value of the selected register |
| halted | output | 1 | Core has stopped |
| illegal | output | 1 | Core stopped on an unsupported instruction |

## Verification
Every instruction has a fixed cost of four fetch cycles plus one, two or four execute cycles. From its reference interpreter, the bench therefore predicts the exact clock edge after reset release at which `halted` first reads high. It counts edges and samples at the falling edge after each one. Register results appear on the edge that ends the execute state, and the bench reads them through the debug port only after the core has stopped. Memory contents are compared after the run, because a store completes one edge after its address is set.

// File: rtl/tiny16_pkg.sv
// Package: shared opcode values, control-state encoding and ALU selector
// for the tiny16 core. Assumes the fixed 16-bit instruction layout.
package tiny16_pkg;
    localparam logic [3:0] OPC_BR   = 4'b0000;
    localparam logic [3:0] OPC_ADD  = 4'b0001;
    localparam logic [3:0] OPC_LD   = 4'b0010;
    localparam logic [3:0] OPC_ST   = 4'b0011;
    localparam logic [3:0] OPC_AND  = 4'b0101;
    localparam logic [3:0] OPC_NOT  = 4'b1001;
    localparam logic [3:0] OPC_TRAP = 4'b1111;

    typedef enum logic [3:0] {
        ST_FETCH, ST_READ, ST_MDRF, ST_IRLD, ST_EXEC,
        ST_LDRD, ST_LDMDR, ST_LDWB, ST_STWR, ST_HALT
    } state_e;

    typedef enum logic [1:0] {ALU_ADD, ALU_AND, ALU_NOT, ALU_PASS} alu_op_e;
endpackage

// File: rtl/tiny16_regfile.sv
// Register file: NREG words of XLEN bits, one synchronous write port and
// NRD combinational read ports. Assumes a synchronous active-low reset
// that clears every entry.
module tiny16_regfile #(
    parameter int XLEN = 16,
    parameter int NREG = 8,
    parameter int NRD  = 4,
    localparam int RW  = $clog2(NREG)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [RW-1:0]             waddr,
    input  logic [XLEN-1:0]           wdata,
    input  logic [NRD-1:0][RW-1:0]    raddr,
    output logic [NRD-1:0][XLEN-1:0]  rdata
);
    logic [XLEN-1:0] regs [NREG];

    // Write or clear the storage array.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    // One combinational read mux per port.
    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = regs[raddr[g]];
    end
endmodule

// File: rtl/tiny16_alu.sv
// ALU: add, AND, complement or pass-through, plus the one-hot n/z/p code of
// the result. Assumes two's-complement XLEN-bit operands.
module tiny16_alu
    import tiny16_pkg::*;
#(
    parameter int XLEN = 16
) (
    input  alu_op_e          op,
    input  logic [XLEN-1:0]  a,
    input  logic [XLEN-1:0]  b,
    output logic [XLEN-1:0]  y,
    output logic [2:0]       nzp
);
    // Select the operation result.
    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_AND: y = a & b;
            ALU_NOT: y = ~a;
            default: y = a;
        endcase
    end

    // Derive the condition code from the result.
    always_comb begin
        if (y[XLEN-1])   nzp = 3'b100;
        else if (y == '0) nzp = 3'b010;
        else             nzp = 3'b001;
    end
endmodule

// File: rtl/tiny16_decode.sv
// Decoder: classifies the instruction register, extracts register fields,
// sign-extends immediates and evaluates the branch condition. Assumes the
// fixed 16-bit field layout; anything outside the subset is flagged illegal.
module tiny16_decode
    import tiny16_pkg::*;
#(
    parameter int          XLEN     = 16,
    parameter logic [7:0]  HALT_VEC = 8'h25
) (
    input  logic [15:0]      ir,
    input  logic [2:0]       cc,
    output logic [2:0]       dr,
    output logic [2:0]       sr1,
    output logic [2:0]       sr2,
    output logic             use_imm,
    output logic [XLEN-1:0]  imm5_x,
    output logic [XLEN-1:0]  off9_x,
    output alu_op_e          alu_op,
    output logic             is_op,
    output logic             is_br,
    output logic             is_ld,
    output logic             is_st,
    output logic             is_halt,
    output logic             is_bad,
    output logic             br_taken
);
    assign dr       = ir[11:9];
    assign sr1      = ir[8:6];
    assign sr2      = ir[2:0];
    assign use_imm  = ir[5];
    assign imm5_x   = {{(XLEN-5){ir[4]}}, ir[4:0]};
    assign off9_x   = {{(XLEN-9){ir[8]}}, ir[8:0]};
    assign br_taken = |(ir[11:9] & cc);

    // Classify the opcode and choose the ALU operation.
    always_comb begin
        is_op   = 1'b0;
        is_br   = 1'b0;
        is_ld   = 1'b0;
        is_st   = 1'b0;
        is_halt = 1'b0;
        is_bad  = 1'b0;
        alu_op  = ALU_ADD;
        case (ir[15:12])
            OPC_ADD: is_op = 1'b1;
            OPC_AND: begin is_op = 1'b1; alu_op = ALU_AND; end
            OPC_NOT: begin
                alu_op = ALU_NOT;
                if (ir[5:0] == 6'b111111) is_op = 1'b1;
                else                      is_bad = 1'b1;
            end
            OPC_BR:  is_br = 1'b1;
            OPC_LD:  is_ld = 1'b1;
            OPC_ST:  is_st = 1'b1;
            OPC_TRAP: begin
                if (ir[11:8] == 4'b0000 && ir[7:0] == HALT_VEC) is_halt = 1'b1;
                else                                           is_bad = 1'b1;
            end
            default: is_bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/tiny16_core.sv
// Top: multicycle control and datapath of the tiny16 core. The memory
// address comes from the MAR, read data is captured into the MDR and only
// read accesses load it. Assumes a synchronous single-port memory with one
// cycle of read latency, and a synchronous active-low reset.
module tiny16_core
    import tiny16_pkg::*;
#(
    parameter int          XLEN     = 16,
    parameter int          NREG     = 8,
    parameter logic [15:0] RESET_PC = 16'h3000,
    parameter logic [7:0]  HALT_VEC = 8'h25,
    localparam int         RW       = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [XLEN-1:0]  mem_addr,
    output logic             mem_re,
    output logic             mem_we,
    output logic [XLEN-1:0]  mem_wdata,
    input  logic [XLEN-1:0]  mem_rdata,
    input  logic [RW-1:0]    dbg_sel,
    output logic [XLEN-1:0]  dbg_data,
    output logic             halted,
    output logic             illegal
);
    localparam int NRD = 4;

    state_e          state_q;
    logic [XLEN-1:0] pc_q, mar_q, mdr_q;
    logic [15:0]     ir_q;
    logic [2:0]      cc_q;
    logic            halted_q, illegal_q;

    logic [2:0]      dr, sr1, sr2;
    logic            use_imm, is_op, is_br, is_ld, is_st, is_halt, is_bad, br_taken;
    logic [XLEN-1:0] imm5_x, off9_x;
    alu_op_e         dec_op, alu_op;
    logic [XLEN-1:0] alu_a, alu_b, alu_y;
    logic [2:0]      alu_nzp;
    logic            rf_we;
    logic [NRD-1:0][RW-1:0]   rf_ra;
    logic [NRD-1:0][XLEN-1:0] rf_rd;

    tiny16_decode #(.XLEN(XLEN), .HALT_VEC(HALT_VEC)) u_dec (
        .ir(ir_q), .cc(cc_q), .dr(dr), .sr1(sr1), .sr2(sr2),
        .use_imm(use_imm), .imm5_x(imm5_x), .off9_x(off9_x), .alu_op(dec_op),
        .is_op(is_op), .is_br(is_br), .is_ld(is_ld), .is_st(is_st),
        .is_halt(is_halt), .is_bad(is_bad), .br_taken(br_taken)
    );

    // Read ports: 0 first source, 1 second source, 2 store source, 3 debug.
    assign rf_ra[0] = RW'(sr1);
    assign rf_ra[1] = RW'(sr2);
    assign rf_ra[2] = RW'(dr);
    assign rf_ra[3] = dbg_sel;

    tiny16_regfile #(.XLEN(XLEN), .NREG(NREG), .NRD(NRD)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(RW'(dr)),
        .wdata(alu_y), .raddr(rf_ra), .rdata(rf_rd)
    );

    // ALU operand and operation selection; a load writes back the MDR.
    always_comb begin
        if (state_q == ST_LDWB) begin
            alu_op = ALU_PASS;
            alu_a  = mdr_q;
        end else begin
            alu_op = dec_op;
            alu_a  = rf_rd[0];
        end
        alu_b = use_imm ? imm5_x : rf_rd[1];
    end

    tiny16_alu #(.XLEN(XLEN)) u_alu (
        .op(alu_op), .a(alu_a), .b(alu_b), .y(alu_y), .nzp(alu_nzp)
    );

    assign rf_we     = (state_q == ST_EXEC && is_op) || state_q == ST_LDWB;
    assign mem_addr  = mar_q;
    assign mem_re    = (state_q == ST_READ) || (state_q == ST_LDRD);
    assign mem_we    = (state_q == ST_STWR);
    assign mem_wdata = rf_rd[2];
    assign dbg_data  = rf_rd[3];
    assign halted    = halted_q;
    assign illegal   = illegal_q;

    // Control sequence and architectural state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_FETCH;
            pc_q      <= RESET_PC;
            mar_q     <= '0;
            mdr_q     <= '0;
            ir_q      <= '0;
            cc_q      <= 3'b010;
            halted_q  <= 1'b0;
            illegal_q <= 1'b0;
        end else begin
            case (state_q)
                ST_FETCH: begin
                    mar_q   <= pc_q;
                    pc_q    <= pc_q + 1'b1;
                    state_q <= ST_READ;
                end
                ST_READ:  state_q <= ST_MDRF;
                ST_MDRF: begin
                    mdr_q   <= mem_rdata;
                    state_q <= ST_IRLD;
                end
                ST_IRLD: begin
                    ir_q    <= mdr_q[15:0];
                    state_q <= ST_EXEC;
                end
                ST_EXEC: begin
                    if (is_bad) begin
                        halted_q  <= 1'b1;
                        illegal_q <= 1'b1;
                        state_q   <= ST_HALT;
                    end else if (is_halt) begin
                        halted_q <= 1'b1;
                        state_q  <= ST_HALT;
                    end else if (is_ld || is_st) begin
                        mar_q   <= pc_q + off9_x;
                        state_q <= is_ld ? ST_LDRD : ST_STWR;
                    end else begin
                        if (is_op) cc_q <= alu_nzp;
                        if (is_br && br_taken) pc_q <= pc_q + off9_x;
                        state_q <= ST_FETCH;
                    end
                end
                ST_LDRD:  state_q <= ST_LDMDR;
                ST_LDMDR: begin
                    mdr_q   <= mem_rdata;
                    state_q <= ST_LDWB;
                end
                ST_LDWB: begin
                    cc_q    <= alu_nzp;
                    state_q <= ST_FETCH;
                end
                ST_STWR:  state_q <= ST_FETCH;
                default:  state_q <= ST_HALT;
            endcase
        end
    end
endmodule

// File: rtl/tiny16_checker.sv
// Checker: protocol and state properties of the tiny16 core, bound to the
// top module. Assumes the synchronous active-low reset of the core.
module tiny16_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       mem_re,
    input logic       mem_we,
    input logic       halted,
    input logic       illegal,
    input logic [2:0] cc
);
    assert_no_rw_clash_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));
    assert_read_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> !mem_re);
    assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);
    assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_re && !mem_we));
    assert_illegal_halts_R10: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> halted);
    assert_illegal_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> illegal);
    assert_cc_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cc) == 1);
endmodule

bind tiny16_core tiny16_checker u_chk (
    .clk(clk), .rst_n(rst_n), .mem_re(mem_re), .mem_we(mem_we),
    .halted(halted), .illegal(illegal), .cc(cc_q)
);

// File: tb/test_tiny16_core.sv
// Bench: reference interpreter plus random and directed programs.
module test_tiny16_core;
    localparam int MW  = 4096;
    localparam int CMP = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr, mem_wdata, mem_rdata, dbg_data;
    logic        mem_re, mem_we, halted, illegal;
    logic [2:0]  dbg_sel = 3'd0;

    logic [15:0] mem  [MW];
    logic [15:0] pmem [CMP];
    logic [15:0] gmem [CMP];
    logic [15:0] greg [8];
    logic        ld_en = 1'b0;
    logic [11:0] ld_addr = '0;
    logic [15:0] ld_data = '0;
    logic        seen_rd;
    logic [15:0] first_ra;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    tiny16_core i_tiny16_core (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_re(mem_re),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .dbg_sel(dbg_sel), .dbg_data(dbg_data), .halted(halted), .illegal(illegal)
    );

    // Memory model: one-cycle read latency, bench load port.
    always @(posedge clk) begin
        if (ld_en) mem[ld_addr] <= ld_data;
        if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr[11:0]];
        if (!rst_n) seen_rd <= 1'b0;
        else if (mem_re && !seen_rd) begin
            seen_rd  <= 1'b1;
            first_ra <= mem_addr;
        end
    end

    initial begin
        #(8 * 190000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] flags(input logic [15:0] y);
        if (y[15]) return 3'b100;
        if (y == 16'h0) return 3'b010;
        return 3'b001;
    endfunction

    // Reference interpreter over gmem, cycles per R11.
    task automatic golden_run(output int cyc, output bit gill);
        logic [15:0] pc, ir, a, b, y, ea, s9, s5;
        logic [2:0]  cc;
        bit done;
        pc = 16'h3000; cc = 3'b010; cyc = 0; gill = 0; done = 0;
        for (int r = 0; r < 8; r++) greg[r] = 16'h0;
        for (int s = 0; s < 3000 && !done; s++) begin
            ir = gmem[pc[8:0]];
            pc = pc + 16'd1;
            cyc += 5;
            s9 = {{7{ir[8]}}, ir[8:0]};
            s5 = {{11{ir[4]}}, ir[4:0]};
            a  = greg[ir[8:6]];
            b  = ir[5] ? s5 : greg[ir[2:0]];
            ea = pc + s9;
            case (ir[15:12])
                4'b0001, 4'b0101: begin
                    y = (ir[15:12] == 4'b0001) ? a + b : a & b;
                    greg[ir[11:9]] = y; cc = flags(y);
                end
                4'b1001: begin
                    if (ir[5:0] == 6'h3F) begin
                        y = ~a; greg[ir[11:9]] = y; cc = flags(y);
                    end else begin gill = 1; done = 1; end
                end
                4'b0000: if ((ir[11:9] & cc) != 3'b000) pc = pc + s9;
                4'b0010: begin
                    y = gmem[ea[8:0]]; greg[ir[11:9]] = y; cc = flags(y); cyc += 3;
                end
                4'b0011: begin gmem[ea[8:0]] = greg[ir[11:9]]; cyc += 1; end
                4'b1111: begin
                    if (!(ir[11:8] == 4'h0 && ir[7:0] == 8'h25)) gill = 1;
                    done = 1;
                end
                default: begin gill = 1; done = 1; end
            endcase
        end
    endtask

    // Load pmem, check reset state, run the core and compare to the model.
    task automatic run_prog(input string tag);
        int  gcyc, cyc;
        bit  gill;
        int  bad_idx;
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < CMP; i++) begin
            @(negedge clk);
            ld_en = 1'b1; ld_addr = 12'(i); ld_data = pmem[i];
            gmem[i] = pmem[i];
        end
        @(negedge clk);
        ld_en = 1'b0;
        @(negedge clk);
        check({tag, " R1 reset halted"}, {31'd0, halted}, 32'd0);
        check({tag, " R1 reset illegal"}, {31'd0, illegal}, 32'd0);
        for (int r = 0; r < 8; r++) begin
            dbg_sel = 3'(r); #1;
            check({tag, " R1 reset reg"}, {16'd0, dbg_data}, 32'd0);
        end
        golden_run(gcyc, gill);
        rst_n = 1'b1;
        cyc = 0;
        while (cyc < 20000) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (halted) break;
        end
        check({tag, " R11 cycles to halt"}, cyc, gcyc);
        check({tag, " R1 first fetch addr"}, {16'd0, first_ra}, 32'h3000);
        check({tag, " R10 illegal flag"}, {31'd0, illegal}, {31'd0, gill});
        for (int r = 0; r < 8; r++) begin
            dbg_sel = 3'(r); #1;
            check({tag, " R12 reg value"}, {16'd0, dbg_data}, {16'd0, greg[r]});
        end
        bad_idx = -1;
        for (int i = 0; i < CMP; i++)
            if (bad_idx < 0 && mem[i] !== gmem[i]) bad_idx = i;
        check({tag, " R8 memory image"}, bad_idx, -1);
        repeat (3) @(negedge clk);
        check({tag, " R9 halted sticky"}, {31'd0, halted}, 32'd1);
    endtask

    function automatic logic [15:0] rand_instr();
        logic [2:0] d, s1, s2;
        logic [15:0] w;
        d = 3'($urandom); s1 = 3'($urandom); s2 = 3'($urandom);
        case ($urandom % 8)
            0: w = {4'b0001, d, s1, 3'b000, s2};
            1: w = {4'b0001, d, s1, 1'b1, 5'($urandom)};
            2: w = {4'b0101, d, s1, 3'b000, s2};
            3: w = {4'b0101, d, s1, 1'b1, 5'($urandom)};
            4: w = {4'b1001, d, s1, 6'h3F};
            5: w = {4'b0000, 3'($urandom), 9'($urandom % 3)};
            6: w = {4'b0010, d, 9'(150 + $urandom % 100)};
            default: w = {4'b0011, d, 9'(150 + $urandom % 100)};
        endcase
        return w;
    endfunction

    task automatic clear_prog();
        for (int i = 0; i < CMP; i++) pmem[i] = 16'(i * 16'h1357 + 16'h0101);
    endtask

    localparam logic [15:0] HALT = 16'hF025;

    initial begin
        void'($urandom(32'h00C0FFEE));
        // R1: reset flags Z only -> BRz taken skips the add.
        clear_prog();
        pmem[0] = {4'b0000, 3'b010, 9'd1};
        pmem[1] = {4'b0001, 3'd1, 3'd1, 1'b1, 5'd7};
        pmem[2] = HALT;
        run_prog("R1 brz-at-reset");

        // R6: masks 000, 111, n/p selection and a backward loop.
        clear_prog();
        pmem[0] = {4'b0101, 3'd0, 3'd0, 1'b1, 5'd0};
        pmem[1] = {4'b0000, 3'b000, 9'd1};
        pmem[2] = {4'b0001, 3'd1, 3'd1, 1'b1, 5'd1};
        pmem[3] = {4'b0000, 3'b111, 9'd1};
        pmem[4] = {4'b0001, 3'd2, 3'd2, 1'b1, 5'd1};
        pmem[5] = {4'b0001, 3'd3, 3'd0, 1'b1, 5'h1F};
        pmem[6] = {4'b0000, 3'b001, 9'd1};
        pmem[7] = {4'b0001, 3'd4, 3'd4, 1'b1, 5'd5};
        pmem[8] = {4'b0001, 3'd5, 3'd5, 1'b1, 5'd3};
        pmem[9] = {4'b0001, 3'd5, 3'd5, 1'b1, 5'h1F};
        pmem[10] = {4'b0000, 3'b001, 9'h1FE};
        pmem[11] = HALT;
        run_prog("R6 branch masks");

        // R2 R3 R4 R5 R7 R8: imm5 extremes, load, complement, store, BRn.
        clear_prog();
        pmem[0] = {4'b0001, 3'd3, 3'd3, 1'b1, 5'h10};
        pmem[1] = {4'b0101, 3'd4, 3'd3, 1'b1, 5'h0F};
        pmem[2] = {4'b0010, 3'd1, 9'd20};
        pmem[3] = {4'b1001, 3'd2, 3'd1, 6'h3F};
        pmem[4] = {4'b0011, 3'd2, 9'd30};
        pmem[5] = {4'b0000, 3'b100, 9'd1};
        pmem[6] = {4'b0001, 3'd6, 3'd6, 1'b1, 5'd9};
        pmem[7] = {4'b0001, 3'd7, 3'd3, 3'b000, 3'd4};
        pmem[8] = HALT;
        pmem[23] = 16'h00A5;
        run_prog("R7 load-not-store");

        // R4 R10: bad NOT form, reserved opcode, wrong vector, nonzero [11:8].
        clear_prog();
        pmem[0] = {4'b0001, 3'd1, 3'd1, 1'b1, 5'd4};
        pmem[1] = {4'b1001, 3'd1, 3'd1, 6'h00};
        pmem[2] = {4'b0001, 3'd2, 3'd2, 1'b1, 5'd1};
        run_prog("R4 bad not");
        clear_prog();
        pmem[0] = 16'hD123;
        run_prog("R10 reserved opcode");
        clear_prog();
        pmem[0] = 16'hF021;
        run_prog("R10 other vector");
        clear_prog();
        pmem[0] = 16'hF125;
        run_prog("R10 trap upper bits");

        // Random programs: R2 R3 R5 R6 R7 R8 R11 against the interpreter.
        for (int t = 0; t < 8; t++) begin
            for (int i = 0; i < CMP; i++) pmem[i] = 16'($urandom);
            for (int i = 0; i < 28; i++) pmem[i] = rand_instr();
            for (int i = 28; i < 32; i++) pmem[i] = HALT;
            run_prog("R2 random");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule